// File: doc/BRIEF.md
# Stereo Serial Audio Receiver

This block takes a two-channel serial audio stream and turns it into parallel stereo sample pairs. The stream has three lines: a bit clock, a word-select line and a serial data line. All three are brought into the system clock domain through a synchronizer. A rising edge on the synchronized bit clock samples one data bit. Words are two's complement and arrive most significant bit first. The word-select level tells which channel a word belongs to: low is left, high is right. Framing follows the common one-bit-delay convention. The word-select line switches one slot before the first bit of the next word, so the slot in which it switches still carries the last bit of the word that is ending.

Each finished word is placed left-justified in a 24-bit sample. Any bit positions the stream did not fill are zero. A 2-bit ratio select gives the number of bit-clock cycles per word-clock period: 32, 48 or 64. That number sets how many leading bits of each word are kept. The block holds a left word until the following right word arrives, then presents both on one output strobe. A right word with no held left word before it is dropped. A stream that runs right-then-left therefore pairs each left word with the next right word, one sample period later.

Top module: `stereo_serial_rx`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `pair_valid` is 0 and `left_out` and `right_out` are all zeros.
- R2: After reset, no word is delivered until a word-select change has been seen. The word that this first change closes is partial and is discarded, so it is never paired.
- R3: Data is MSB first and the first received bit lands in bit 23. When fewer than 24 bits are kept, the remaining low bits are 0. With ratio code 0, 16 bits are kept, so bits 7:0 are zero.
- R4: Ratio codes are 0 = 32, 1 = 48, and 2 or 3 = 64 bit clocks per word-clock period. Each word keeps its first min(ratio/2, 24) bits, and any later bits of that word have no effect on the output.
- R5: A word is tagged left when word-select was 0 during its bits and right when it was 1. The bit sampled on the edge where word-select first shows its new level is the last bit of the previous word.
- R6: A left word followed by a right word gives exactly one `pair_valid` pulse, with the left word on `left_out` and the right word on `right_out`.
- R7: A right word with no held left word produces no pulse and is discarded. A later left word pairs with the right word that follows it, not with the discarded one.
- R8: `pair_valid` is high for exactly one clock cycle. It rises on the 4th rising `clk` edge after the bit-clock rising edge that closes the right word (with the default of 2 synchronizer stages).
- R9: `left_out` and `right_out` change only on a cycle where `pair_valid` is high. A left word that is received and held without a right word leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sck_in | input | 1 | Serial bit clock, asynchronous to clk |
| ws_in | input | 1 | Word select: 0 left, 1 right |
| sd_in | input | 1 | Serial data, MSB first |
| fs_ratio | input | 2 | Bit clocks per word-clock period: 0=32, 1=48, 2/3=64 |
| pair_valid | output | 1 | One-cycle strobe for a new stereo pair |
| left_out | output | 24 | Left sample, left-justified two's complement |
| right_out | output | 24 | Right sample, left-justified two's complement |

## Verification
A pair strobe is due on the fourth system-clock edge after the bit-clock rise that carries the closing bit of the right word. The bench records the clock count at each bit-clock rise it drives and compares the delay of every strobe with that figure. Input lines change only at falling clock edges, and each bit-clock half period is four system cycles. This way every strobe lands inside a known half period. Results are sampled at falling edges, away from the register updates, and a strobe that lasts two cycles shows up as a second counted pair.

// File: rtl/arx_pkg.sv
package arx_pkg;

    localparam int SAMPLE_W = 24;

    typedef enum logic [1:0] {
        RATIO_32  = 2'd0,
        RATIO_48  = 2'd1,
        RATIO_64  = 2'd2,
        RATIO_64X = 2'd3
    } ratio_e;

    typedef struct packed {
        logic                right;
        logic [SAMPLE_W-1:0] data;
    } word_t;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } pair_t;

    function automatic int slots_per_word(ratio_e r);
        case (r)
            RATIO_32: return 16;
            RATIO_48: return 24;
            default:  return 32;
        endcase
    endfunction

    function automatic int accept_bits(ratio_e r);
        int s;
        s = slots_per_word(r);
        return (s < SAMPLE_W) ? s : SAMPLE_W;
    endfunction

    function automatic logic [SAMPLE_W-1:0] low_mask(ratio_e r);
        logic [SAMPLE_W-1:0] m;
        int keep;
        keep = accept_bits(r);
        for (int i = 0; i < SAMPLE_W; i++) begin
            m[i] = (i < SAMPLE_W - keep);
        end
        return m;
    endfunction

endpackage

// File: rtl/arx_sync.sv
module arx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_in,
    input  logic ws_in,
    input  logic sd_in,
    output logic sck_rise,
    output logic ws_s,
    output logic sd_s
);
    logic [STAGES-1:0] sck_p;
    logic [STAGES-1:0] ws_p;
    logic [STAGES-1:0] sd_p;
    logic              sck_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p    <= '0;
            ws_p     <= '0;
            sd_p     <= '0;
            sck_last <= 1'b0;
        end else begin
            sck_p    <= {sck_p[STAGES-2:0], sck_in};
            ws_p     <= {ws_p[STAGES-2:0], ws_in};
            sd_p     <= {sd_p[STAGES-2:0], sd_in};
            sck_last <= sck_p[STAGES-1];
        end
    end

    assign sck_rise = sck_p[STAGES-1] & ~sck_last;
    assign ws_s     = ws_p[STAGES-1];
    assign sd_s     = sd_p[STAGES-1];

    // R8: an edge pulse never lasts two cycles
    assert_rise_single_R8: assert property (@(posedge clk) disable iff (rst)
        sck_rise |=> !sck_rise);

endmodule

// File: rtl/arx_shifter.sv
module arx_shifter
    import arx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sck_rise,
    input  logic   ws_s,
    input  logic   sd_s,
    input  ratio_e ratio,
    output logic   word_done,
    output word_t  done_word
);
    localparam int CNT_W = $clog2(SAMPLE_W + 1);

    logic                primed_q;
    logic                locked_q;
    logic                ws_prev_q;
    logic [CNT_W-1:0]    bit_cnt_q;
    logic [SAMPLE_W-1:0] word_q;
    logic [SAMPLE_W-1:0] word_nxt;
    logic                take;
    logic                boundary;
    int                  keep;
    int                  idx;

    always_comb begin
        keep     = accept_bits(ratio);
        take     = int'(bit_cnt_q) < keep;
        idx      = SAMPLE_W - 1 - int'(bit_cnt_q);
        word_nxt = word_q;
        for (int i = 0; i < SAMPLE_W; i++) begin
            if (take && i == idx) begin
                word_nxt[i] = sd_s;
            end
        end
        boundary = primed_q && (ws_s != ws_prev_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            primed_q  <= 1'b0;
            locked_q  <= 1'b0;
            ws_prev_q <= 1'b0;
            bit_cnt_q <= '0;
            word_q    <= '0;
            word_done <= 1'b0;
            done_word <= '0;
        end else begin
            word_done <= 1'b0;
            if (sck_rise) begin
                primed_q  <= 1'b1;
                ws_prev_q <= ws_s;
                if (boundary) begin
                    if (locked_q) begin
                        word_done       <= 1'b1;
                        done_word.right <= ws_prev_q;
                        done_word.data  <= word_nxt;
                    end
                    locked_q  <= 1'b1;
                    word_q    <= '0;
                    bit_cnt_q <= '0;
                end else begin
                    word_q <= word_nxt;
                    if (take) begin
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end
                end
            end
        end
    end

    assert_no_word_before_lock_R2: assert property (@(posedge clk) disable iff (rst)
        !locked_q |-> !word_done);

    assert_low_fill_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (word_done && accept_bits(ratio) < SAMPLE_W) |->
            ((done_word.data & low_mask(ratio)) == '0));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        word_done |=> !word_done);

endmodule

// File: rtl/arx_pairer.sv
module arx_pairer
    import arx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  word_done,
    input  word_t done_word,
    output logic  pair_valid,
    output pair_t pair
);
    logic                have_left_q;
    logic [SAMPLE_W-1:0] held_left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_left_q <= 1'b0;
            held_left_q <= '0;
            pair_valid  <= 1'b0;
            pair        <= '0;
        end else begin
            pair_valid <= 1'b0;
            if (word_done) begin
                if (!done_word.right) begin
                    held_left_q <= done_word.data;
                    have_left_q <= 1'b1;
                end else if (have_left_q) begin
                    pair.left   <= held_left_q;
                    pair.right  <= done_word.data;
                    pair_valid  <= 1'b1;
                    have_left_q <= 1'b0;
                end
            end
        end
    end

    assert_pair_after_right_R6: assert property (@(posedge clk) disable iff (rst)
        pair_valid |-> $past(word_done && done_word.right));

    assert_orphan_right_dropped_R7: assert property (@(posedge clk) disable iff (rst)
        (word_done && done_word.right && !have_left_q) |=> !pair_valid);

    assert_strobe_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        pair_valid |=> !pair_valid);

    assert_outputs_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !pair_valid |-> ($stable(pair.left) && $stable(pair.right)));

endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx
    import arx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sck_in,
    input  logic                ws_in,
    input  logic                sd_in,
    input  logic [1:0]          fs_ratio,
    output logic                pair_valid,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out
);
    logic   sck_rise;
    logic   ws_s;
    logic   sd_s;
    logic   word_done;
    word_t  done_word;
    pair_t  pair;
    ratio_e ratio;

    assign ratio = ratio_e'(fs_ratio);

    arx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sck_in   (sck_in),
        .ws_in    (ws_in),
        .sd_in    (sd_in),
        .sck_rise (sck_rise),
        .ws_s     (ws_s),
        .sd_s     (sd_s)
    );

    arx_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .sck_rise  (sck_rise),
        .ws_s      (ws_s),
        .sd_s      (sd_s),
        .ratio     (ratio),
        .word_done (word_done),
        .done_word (done_word)
    );

    arx_pairer u_pair (
        .clk        (clk),
        .rst        (rst),
        .word_done  (word_done),
        .done_word  (done_word),
        .pair_valid (pair_valid),
        .pair       (pair)
    );

    assign left_out  = pair.left;
    assign right_out = pair.right;

endmodule

// File: tb/test_stereo_serial_rx.sv
module test_stereo_serial_rx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck_in = 1'b0;
    logic        ws_in = 1'b0;
    logic        sd_in = 1'b0;
    logic [1:0]  fs_ratio = 2'd2;
    logic        pair_valid;
    logic [23:0] left_out;
    logic [23:0] right_out;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int last_rise = 0;
    int n_str = 0;
    int lat = 0;
    logic [23:0] cap_l = '0;
    logic [23:0] cap_r = '0;

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    stereo_serial_rx i_stereo_serial_rx (
        .clk        (clk),
        .rst        (rst),
        .sck_in     (sck_in),
        .ws_in      (ws_in),
        .sd_in      (sd_in),
        .fs_ratio   (fs_ratio),
        .pair_valid (pair_valid),
        .left_out   (left_out),
        .right_out  (right_out)
    );

    always @(negedge clk) begin
        if (!rst && pair_valid) begin
            n_str = n_str + 1;
            cap_l = left_out;
            cap_r = right_out;
            lat   = cyc - last_rise;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] expect_word(logic [31:0] bits, int slots, int keep_max);
        logic [23:0] r;
        int keep;
        keep = (slots < keep_max) ? slots : keep_max;
        if (keep > 24) keep = 24;
        for (int i = 0; i < 24; i++) begin
            r[23-i] = (i < keep) ? bits[31-i] : 1'b0;
        end
        return r;
    endfunction

    task automatic do_reset(input logic [1:0] ratio);
        @(negedge clk);
        rst = 1'b1;
        fs_ratio = ratio;
        sck_in = 1'b0;
        ws_in = 1'b0;
        sd_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n_str = 0;
    endtask

    task automatic drive_slot(input logic w, input logic d);
        sck_in = 1'b0;
        ws_in = w;
        sd_in = d;
        repeat (4) @(negedge clk);
        sck_in = 1'b1;
        last_rise = cyc;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_word(input logic ch, input logic nxt, input logic [31:0] bits, input int slots);
        for (int j = 0; j < slots; j++) begin
            drive_slot((j == slots - 1) ? nxt : ch, bits[31-j]);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(pair_valid == 1'b0, "R1", "strobe in reset", 32'(pair_valid), 0);
        chk(left_out == 24'h0, "R1", "left in reset", 32'(left_out), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(right_out == 24'h0 && pair_valid == 1'b0, "R1", "right after reset",
            32'(right_out), 0);
    endtask

    task automatic t_basic64();
        logic [31:0] lb = 32'h8000_01A5;
        logic [31:0] rb = 32'h7FFF_FE5A;
        do_reset(2'd2);
        send_word(1'b1, 1'b0, 32'hFFFF_FFFF, 32);
        send_word(1'b0, 1'b1, lb, 32);
        send_word(1'b1, 1'b0, rb, 32);
        repeat (4) @(negedge clk);
        chk(n_str == 1, "R6", "pair count ratio64", n_str, 1);
        chk(cap_l == expect_word(lb, 32, 24), "R5", "left ratio64", cap_l, expect_word(lb, 32, 24));
        chk(cap_r == expect_word(rb, 32, 24), "R4", "right ratio64 low bits dropped",
            cap_r, expect_word(rb, 32, 24));
        chk(lat == 4, "R8", "strobe latency", lat, 4);
    endtask

    task automatic t_ratio48();
        logic [31:0] lb = 32'hC0FF_EE00;
        logic [31:0] rb = 32'h1234_5600;
        do_reset(2'd1);
        send_word(1'b1, 1'b0, 32'hFFFF_FFFF, 24);
        send_word(1'b0, 1'b1, lb, 24);
        send_word(1'b1, 1'b0, rb, 24);
        repeat (4) @(negedge clk);
        chk(n_str == 1, "R6", "pair count ratio48", n_str, 1);
        chk(cap_l == 24'hC0FFEE, "R4", "left ratio48", cap_l, 24'hC0FFEE);
        chk(cap_r == 24'h123456, "R4", "right ratio48", cap_r, 24'h123456);
    endtask

    task automatic t_ratio32();
        logic [31:0] lb = 32'hBEEF_0000;
        logic [31:0] rb = 32'h0123_0000;
        do_reset(2'd0);
        send_word(1'b1, 1'b0, 32'hFFFF_FFFF, 16);
        send_word(1'b0, 1'b1, lb, 16);
        send_word(1'b1, 1'b0, rb, 16);
        repeat (4) @(negedge clk);
        chk(cap_l == 24'hBEEF00, "R3", "left zero fill", cap_l, 24'hBEEF00);
        chk(cap_r == 24'h012300, "R3", "right zero fill", cap_r, 24'h012300);
        chk(lat == 4, "R8", "strobe latency ratio32", lat, 4);
    endtask

    task automatic t_extra_bits();
        logic [31:0] lb = 32'hFACE_B00C;
        logic [31:0] rb = 32'h5555_AAAA;
        do_reset(2'd0);
        send_word(1'b1, 1'b0, 32'hFFFF_FFFF, 32);
        send_word(1'b0, 1'b1, lb, 32);
        send_word(1'b1, 1'b0, rb, 32);
        repeat (4) @(negedge clk);
        chk(n_str == 1, "R4", "pair count long words", n_str, 1);
        chk(cap_l == 24'hFACE00, "R4", "left bits past 16 ignored", cap_l, 24'hFACE00);
        chk(cap_r == 24'h555500, "R4", "right bits past 16 ignored", cap_r, 24'h555500);
    endtask

    task automatic t_lock_and_orphan();
        logic [31:0] ra = 32'hAAAA_AA00;
        logic [31:0] lb = 32'h0F0F_0F00;
        logic [31:0] rc = 32'hF0F0_F000;
        do_reset(2'd2);
        send_word(1'b0, 1'b1, 32'h1357_9BDF, 32);
        send_word(1'b1, 1'b0, ra, 32);
        repeat (4) @(negedge clk);
        chk(n_str == 0, "R2", "partial first word not paired", n_str, 0);
        send_word(1'b0, 1'b1, lb, 32);
        send_word(1'b1, 1'b0, rc, 32);
        repeat (4) @(negedge clk);
        chk(n_str == 1, "R7", "one pair after orphan right", n_str, 1);
        chk(cap_l == 24'h0F0F0F, "R7", "left after orphan", cap_l, 24'h0F0F0F);
        chk(cap_r == 24'hF0F0F0, "R7", "right pairs with later word", cap_r, 24'hF0F0F0);
    endtask

    task automatic t_hold();
        do_reset(2'd1);
        send_word(1'b1, 1'b0, 32'hFFFF_FFFF, 24);
        send_word(1'b0, 1'b1, 32'h1111_1100, 24);
        send_word(1'b1, 1'b0, 32'h2222_2200, 24);
        repeat (4) @(negedge clk);
        n_str = 0;
        send_word(1'b0, 1'b1, 32'h9999_9900, 24);
        repeat (8) @(negedge clk);
        chk(n_str == 0, "R9", "held left gives no strobe", n_str, 0);
        chk(left_out == 24'h111111, "R9", "left held stable", left_out, 24'h111111);
        chk(right_out == 24'h222222, "R9", "right held stable", right_out, 24'h222222);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_basic64();
        t_ratio48();
        t_ratio32();
        t_extra_bits();
        t_lock_and_orphan();
        t_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule